// File: doc/BRIEF.md
# Seven-Instruction Main Control Decoder

This block turns the 6-bit primary opcode and the 6-bit function field of a 32-bit instruction into the control points of a single-cycle datapath. These are the destination-register select, the immediate operand select, the load write-back select, the register and data-memory write enables, the branch and jump selects, the immediate sign-extension enable and a 2-bit ALU operation. It is purely combinational. It sits between the instruction memory output and the datapath multiplexers.

Decoding takes two planes. The AND plane has one product term per supported instruction, seven in all. Each term matches the opcode and, for the register-format group, also the function field. The OR plane builds each control output as the OR of the terms named in a constant mask. An encoding that matches no term raises the illegal-instruction flag. Because no term fires, it also leaves every control output low, so it cannot change architectural state.

Top module: `ctl_decoder`

## Requirements
- R1: Opcode 000000 with function 100000 (add) drives dst_rd_sel=1 and rf_wen=1, alu_op=00 (add), and all other controls 0.
- R2: Opcode 000000 with function 100010 (subtract) drives dst_rd_sel=1 and rf_wen=1, alu_op=01 (subtract), and all other controls 0.
- R3: Opcode 001101 (or-immediate) drives alu_imm_sel=1 and rf_wen=1, alu_op=10 (or), with imm_sext=0 and all other controls 0.
- R4: Opcode 100011 (load word) drives alu_imm_sel, wb_from_mem, rf_wen and imm_sext to 1, with alu_op=00 and all other controls 0.
- R5: Opcode 101011 (store word) drives alu_imm_sel, dmem_wen and imm_sext to 1, with alu_op=00 and all other controls 0.
- R6: Opcode 000100 (branch if equal) drives br_eq_sel=1 and alu_op=01, with all other controls 0.
- R7: Opcode 000010 (jump) drives jmp_sel=1 and every other control to 0, including alu_op=00.
- R8: For the five non-zero supported opcodes, the function field has no effect on any output.
- R9: Any other opcode, and opcode 000000 with any function other than 100000 or 100010, drives illegal_inst=1 and every control output to 0. This includes rf_wen, dmem_wen, br_eq_sel and jmp_sel.
- R10: illegal_inst is 0 for every supported encoding.
- R11: alu_op never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field of the instruction |
| funct | input | 6 | Function field, used only when opcode is 000000 |
| dst_rd_sel | output | 1 | Write-back register comes from the third register field |
| alu_imm_sel | output | 1 | Second ALU operand is the extended immediate |
| wb_from_mem | output | 1 | Register write data comes from data memory |
| rf_wen | output | 1 | Register file write enable |
| dmem_wen | output | 1 | Data memory write enable |
| br_eq_sel | output | 1 | Next-PC takes the equal-branch path |
| jmp_sel | output | 1 | Next-PC takes the jump target |
| imm_sext | output | 1 | Immediate is sign-extended (else zero-extended) |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 or |
| illegal_inst | output | 1 | No supported instruction matched |

## Verification
Several outputs can be active for one instruction, so the sweep must judge them together. A load raises four controls in the same evaluation. A branch shares the subtract ALU code with the subtract instruction, and the two come from different product terms. The bench drives all 4096 opcode and function combinations one per clock. It compares the whole control word against a model written from the encodings above. Each encoding is also judged on whether the illegal flag and the ALU code agree with it. Function values under non-zero opcodes are where leakage of the function field into the decode would show.

// File: rtl/ctl_decoder_pkg.sv
package ctl_decoder_pkg;
   localparam int OPC_W   = 6;
   localparam int FN_W    = 6;
   localparam int N_TERMS = 7;
   localparam int N_CTL   = 10;

   // product term order: 0 add, 1 sub, 2 ori, 3 lw, 4 sw, 5 beq, 6 jmp
   localparam logic [N_TERMS-1:0][OPC_W-1:0] TERM_OPC = {
      6'b000010, 6'b000100, 6'b101011, 6'b100011, 6'b001101, 6'b000000, 6'b000000};
   localparam logic [N_TERMS-1:0] TERM_USE_FN = 7'b0000011;
   localparam logic [N_TERMS-1:0][FN_W-1:0] TERM_FN = {
      6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'b100010, 6'b100000};

   // control index order (LSB first): alu0, alu1, sext, jmp, br, dmem, rfw, wbm, imm, dst
   localparam int C_ALU0 = 0, C_ALU1 = 1, C_SEXT = 2, C_JMP = 3, C_BR = 4;
   localparam int C_DMEM = 5, C_RFW = 6, C_WBM = 7, C_IMM = 8, C_DST = 9;

   localparam logic [N_CTL-1:0][N_TERMS-1:0] CTL_MASK = {
      7'b0000011,   // dst
      7'b0011100,   // imm
      7'b0001000,   // wbm
      7'b0001111,   // rfw
      7'b0010000,   // dmem
      7'b0100000,   // br
      7'b1000000,   // jmp
      7'b0011000,   // sext
      7'b0000100,   // alu1
      7'b0100010};  // alu0
endpackage

// File: rtl/insn_match_plane.sv
module insn_match_plane
   import ctl_decoder_pkg::*;
#(
   parameter int                              OW    = OPC_W,
   parameter int                              FW    = FN_W,
   parameter int                              NT    = N_TERMS,
   parameter logic [NT-1:0][OW-1:0]           OPCS  = TERM_OPC,
   parameter logic [NT-1:0]                   USEFN = TERM_USE_FN,
   parameter logic [NT-1:0][FW-1:0]           FNS   = TERM_FN
) (
   input  logic [OW-1:0] opc,
   input  logic [FW-1:0] fn,
   output logic [NT-1:0] hit
);
   if (NT < 1) begin : g_bad_nt
      $error("insn_match_plane: at least one product term required");
   end

   for (genvar t = 0; t < NT; t++) begin : g_term
      if (USEFN[t]) begin : g_with_fn
         assign hit[t] = (opc == OPCS[t]) && (fn == FNS[t]);
      end else begin : g_opc_only
         assign hit[t] = (opc == OPCS[t]);
      end
   end
endmodule

// File: rtl/ctl_or_plane.sv
module ctl_or_plane
   import ctl_decoder_pkg::*;
#(
   parameter int                        NT   = N_TERMS,
   parameter int                        NC   = N_CTL,
   parameter logic [NC-1:0][NT-1:0]     MASK = CTL_MASK
) (
   input  logic [NT-1:0] hit,
   output logic [NC-1:0] ctl
);
   if (NC < 1) begin : g_bad_nc
      $error("ctl_or_plane: at least one control output required");
   end

   for (genvar k = 0; k < NC; k++) begin : g_out
      assign ctl[k] = |(hit & MASK[k]);
   end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
   import ctl_decoder_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  funct,
   output logic             dst_rd_sel,
   output logic             alu_imm_sel,
   output logic             wb_from_mem,
   output logic             rf_wen,
   output logic             dmem_wen,
   output logic             br_eq_sel,
   output logic             jmp_sel,
   output logic             imm_sext,
   output logic [1:0]       alu_op,
   output logic             illegal_inst
);
   if (N_CTL != 10 || N_TERMS != 7) begin : g_bad_cfg
      $error("ctl_decoder: control or term count does not match port list");
   end

   logic [N_TERMS-1:0] hit;
   logic [N_CTL-1:0]   ctl;

   insn_match_plane u_and (.opc(opcode), .fn(funct), .hit(hit));
   ctl_or_plane     u_or  (.hit(hit), .ctl(ctl));

   assign illegal_inst = ~|hit;
   assign dst_rd_sel   = ctl[C_DST];
   assign alu_imm_sel  = ctl[C_IMM];
   assign wb_from_mem  = ctl[C_WBM];
   assign rf_wen       = ctl[C_RFW];
   assign dmem_wen     = ctl[C_DMEM];
   assign br_eq_sel    = ctl[C_BR];
   assign jmp_sel      = ctl[C_JMP];
   assign imm_sext     = ctl[C_SEXT];
   assign alu_op       = {ctl[C_ALU1], ctl[C_ALU0]};

   always_comb begin
      // R9: an unmatched encoding leaves no state-changing control high
      assert_illegal_quiet_R9: assert (!illegal_inst ||
         !(rf_wen || dmem_wen || br_eq_sel || jmp_sel));
      // R10: at most one instruction term matches any encoding
      assert_single_term_R10: assert ($onehot0(hit));
      // R11: the unused ALU code is never produced
      assert_alu_code_R11: assert (alu_op != 2'b11);
      // R4: a memory write-back comes with immediate, extension and register write
      assert_load_bundle_R4: assert (!wb_from_mem || (alu_imm_sel && imm_sext && rf_wen));
      // R5: a store never writes the register file
      assert_store_no_rfw_R5: assert (!dmem_wen || !rf_wen);
      // R1: register-field destination only under the all-zero opcode
      assert_dst_rtype_R1: assert (!dst_rd_sel || opcode == '0);
   end
endmodule

// File: tb/ctl_decoder_bench.sv
module ctl_decoder_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic [5:0] opcode = '0;
   logic [5:0] funct  = '0;
   logic dst_rd_sel, alu_imm_sel, wb_from_mem, rf_wen, dmem_wen;
   logic br_eq_sel, jmp_sel, imm_sext, illegal_inst;
   logic [1:0] alu_op;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctl_decoder u_ctl_decoder (
      .opcode(opcode), .funct(funct),
      .dst_rd_sel(dst_rd_sel), .alu_imm_sel(alu_imm_sel), .wb_from_mem(wb_from_mem),
      .rf_wen(rf_wen), .dmem_wen(dmem_wen), .br_eq_sel(br_eq_sel), .jmp_sel(jmp_sel),
      .imm_sext(imm_sext), .alu_op(alu_op), .illegal_inst(illegal_inst));

   // word layout: {illegal, dst, imm, wbm, rfw, dmem, br, jmp, sext, alu_op[1:0]}
   function automatic logic [10:0] model(input logic [5:0] op, input logic [5:0] fn);
      logic [10:0] w;
      w = '0;
      if (op == 6'd0 && fn == 6'd32)      w = 11'b0_1001_0000_00;       // add  R1
      else if (op == 6'd0 && fn == 6'd34) w = 11'b0_1001_0000_01;       // sub  R2
      else if (op == 6'd13)               w = 11'b0_0101_0000_10;       // ori  R3
      else if (op == 6'd35)               w = 11'b0_0111_0001_00;       // lw   R4
      else if (op == 6'd43)               w = 11'b0_0100_1001_00;       // sw   R5
      else if (op == 6'd4)                w = 11'b0_0000_0100_01;       // beq  R6
      else if (op == 6'd2)                w = 11'b0_0000_0010_00;       // jmp  R7
      else                                w = 11'b1_0000_0000_00;       // R9
      return w;
   endfunction

   function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
      if (op == 6'd0 && fn == 6'd32) return "R1";
      if (op == 6'd0 && fn == 6'd34) return "R2";
      if (op == 6'd0) return "R9";
      if (op != 6'd13 && op != 6'd35 && op != 6'd43 && op != 6'd4 && op != 6'd2) return "R9";
      if (fn != 6'd0) return "R8";
      case (op)
         6'd13:   return "R3";
         6'd35:   return "R4";
         6'd43:   return "R5";
         6'd4:    return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, opcode, funct, act, exp);
      end
   endtask

   initial begin
      logic [10:0] act, exp;
      for (int i = 0; i < 4096; i++) begin
         @(posedge clk);
         opcode = i[11:6];
         funct  = i[5:0];
         @(negedge clk);
         act = {illegal_inst, dst_rd_sel, alu_imm_sel, wb_from_mem, rf_wen, dmem_wen,
                br_eq_sel, jmp_sel, imm_sext, alu_op};
         exp = model(opcode, funct);
         check(tag_of(opcode, funct), act, exp);
         // R10 / R9: illegal flag alone
         check(exp[10] ? "R9" : "R10", {10'd0, illegal_inst}, {10'd0, exp[10]});
         // R11: ALU code never 11
         check("R11", {10'd0, alu_op == 2'b11}, 11'd0);
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(CLK_PERIOD * 10000);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule